// File: doc/BRIEF.md
# DDR2 CKE Power-Down Manager

This block owns the clock-enable level of a DDR2 memory interface and decides when the device may drop into power-down and when it may return. When the controller asks for idle, and no burst is in flight, it lowers CKE. The power-down type follows the bank state at entry: it is precharge power-down when every bank is closed, and active power-down when a row is still open. The type is latched and reported for the whole stay. The block enforces the minimum width of both CKE levels. It holds off entry until the on-die-termination control line has been quiet long enough. A wake request is accepted at any time during power-down and is served as soon as the minimum low width has elapsed.

After exit, two flags tell the command scheduler what it may issue. The non-read flag follows the fixed exit delay. The read flag depends on the power-down type and on the exit mode. Fast exit uses a short fixed delay. Slow exit uses a longer delay that shrinks by the additive latency and is floored at the fast value. A third flag reports when the termination control may change again after exit. The additive latency and the exit mode are taken at the moment of entry.

The controller is a three-state machine. `S_AWAKE` has CKE high with all commands allowed. `S_DOWN` has CKE low. `S_EXIT` has CKE high again while the exit delays run. The transitions are:
- entry (`S_AWAKE`→`S_DOWN`): idle requested, no burst, no wake, termination settled, high width met.
- wake (`S_DOWN`→`S_EXIT`): wake requested now or earlier, low width met.
- ready (`S_EXIT`→`S_AWAKE`): both exit delays elapsed.

Top module: `pd_cke_manager`

## Requirements
- R1: On entry, `pd_active` takes the value of `bank_open` seen in the entry decision cycle (0 = precharge power-down, 1 = active power-down) and holds it while CKE is low and through the following exit.
- R2: CKE falls only after a cycle in which `idle_req` is 1, `burst_busy` is 0 and `wake_req` is 0. While `burst_busy` or `wake_req` stays 1, CKE stays high.
- R3: Each CKE level lasts at least 3 cycles. After reset, CKE is high for exactly 3 cycles before the earliest possible fall.
- R4: `rd_ok` and `nrd_ok` are 0 in every cycle with CKE low.
- R5: After CKE rises, `nrd_ok` stays 0 for exactly 2 cycles and then rises, for both power-down types. For precharge power-down the same 2-cycle delay applies to `rd_ok`.
- R6: After active power-down, `rd_ok` stays 0 for 2 cycles in fast-exit mode (`slow_exit` = 0). In slow-exit mode it stays 0 for 6 − AL cycles, clamped to a minimum of 2. AL (`al`, 0..5) and `slow_exit` are sampled at entry.
- R7: CKE falls only if `odt_chg` was 0 in the last 3 cycles before the fall. With an `odt_chg` pulse in the cycle where `idle_req` rises, CKE remains high for 3 further cycles.
- R8: A wake request during the minimum low window is held and served when the window ends, so CKE is low for exactly 3 cycles. A wake request after the window raises CKE at the next edge.
- R9: `odt_ok` is 0 while CKE is low and for the first 8 cycles after CKE rises, then 1.
- R10: After reset, `cke` = 1, `rd_ok` = 1, `nrd_ok` = 1, `pd_active` = 0 and `odt_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Request to enter power-down |
| burst_busy | input | 1 | A read or write burst is in progress |
| bank_open | input | 1 | At least one row is open |
| wake_req | input | 1 | Request to leave power-down |
| al | input | 3 | Additive latency setting (0..5) |
| slow_exit | input | 1 | 1 = slow-exit active power-down mode |
| odt_chg | input | 1 | Termination control line changes this cycle |
| cke | output | 1 | Clock-enable level to the device |
| pd_active | output | 1 | Latched power-down type: 1 active, 0 precharge |
| rd_ok | output | 1 | A read command may be issued |
| nrd_ok | output | 1 | A non-read command may be issued |
| odt_ok | output | 1 | The termination control may change |

## Verification
The assertions check the following on every cycle:
- each CKE edge came after a level held for the minimum width;
- no fall followed a busy, waking or termination-change cycle;
- the latched type matches the bank state at entry;
- both command flags are low while CKE is low;
- the termination flag is low when CKE rises.

Only the bench scenarios can show the exact exit delays, because these depend on the type, the exit mode and the additive latency. The bench sweeps every combination of these three. The scenarios also show that a held wake is served at the first legal edge and that blocked requests really keep CKE high.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    typedef enum logic [1:0] {
        S_AWAKE = 2'd0,
        S_DOWN  = 2'd1,
        S_EXIT  = 2'd2
    } pd_state_t;

endpackage

// File: rtl/pd_level_timer.sv
// Counts how many cycles the clock-enable level has held its present value,
// including the current cycle. Saturates at CNT_MAX.
module pd_level_timer #(
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl_q,
    input  logic             lvl_d,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] C_MAX = CNT_W'(CNT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (lvl_d != lvl_q) begin
            cnt <= CNT_W'(1);
        end else if (cnt < C_MAX) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pd_odt_quiet.sv
// Tracks quiet cycles on the termination control line; settled means the
// current cycle and the ones before it add up to T_ANPD quiet cycles.
module pd_odt_quiet #(
    parameter int T_ANPD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic odt_chg,
    output logic settled
);
    localparam int QW = $clog2(T_ANPD + 1);
    localparam logic [QW-1:0] Q_NEED = QW'(T_ANPD - 1);

    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= '0;
        end else if (odt_chg) begin
            quiet_q <= '0;
        end else if (quiet_q < Q_NEED) begin
            quiet_q <= quiet_q + QW'(1);
        end
    end

    assign settled = !odt_chg && (quiet_q >= Q_NEED);
endmodule

// File: rtl/pd_exit_calc.sv
// Works out the read delay and the total exit hold for the power-down type
// and the exit settings being entered.
module pd_exit_calc #(
    parameter int AL_W    = 3,
    parameter int CNT_W   = 4,
    parameter int T_XP    = 2,
    parameter int T_XARD  = 2,
    parameter int T_XARDS = 6
) (
    input  logic             row_open,
    input  logic             slow_exit,
    input  logic [AL_W-1:0]  al,
    output logic [CNT_W-1:0] rd_dly,
    output logic [CNT_W-1:0] hold_len
);
    int d;

    always_comb begin
        if (!row_open) begin
            d = T_XP;
        end else if (!slow_exit) begin
            d = T_XARD;
        end else if (int'(al) + T_XARD >= T_XARDS) begin
            d = T_XARD;
        end else begin
            d = T_XARDS - int'(al);
        end
        rd_dly   = CNT_W'(d);
        hold_len = CNT_W'((d > T_XP) ? d : T_XP);
    end
endmodule

// File: rtl/pd_cke_manager.sv
module pd_cke_manager
    import pdm_pkg::*;
#(
    parameter int AL_W      = 3,
    parameter int MIN_PULSE = 3,
    parameter int T_XP      = 2,
    parameter int T_XARD    = 2,
    parameter int T_XARDS   = 6,
    parameter int T_ANPD    = 3,
    parameter int T_AXPD    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle_req,
    input  logic            burst_busy,
    input  logic            bank_open,
    input  logic            wake_req,
    input  logic [AL_W-1:0] al,
    input  logic            slow_exit,
    input  logic            odt_chg,
    output logic            cke,
    output logic            pd_active,
    output logic            rd_ok,
    output logic            nrd_ok,
    output logic            odt_ok
);
    localparam int CNT_A   = (T_AXPD + 1 > T_XARDS + 1) ? T_AXPD + 1 : T_XARDS + 1;
    localparam int CNT_MAX = (CNT_A > MIN_PULSE) ? CNT_A : MIN_PULSE;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] C_MIN  = CNT_W'(MIN_PULSE);
    localparam logic [CNT_W-1:0] C_XP   = CNT_W'(T_XP);
    localparam logic [CNT_W-1:0] C_AXPD = CNT_W'(T_AXPD);

    pd_state_t        state, state_d;
    logic             cke_q, cke_d;
    logic             wake_pend;
    logic             pd_active_q;
    logic [CNT_W-1:0] rd_dly_q, hold_q;
    logic [CNT_W-1:0] rd_dly_c, hold_c;
    logic [CNT_W-1:0] lvl_cnt;
    logic             odt_settled;

    pd_level_timer #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_q (cke_q),
        .lvl_d (cke_d),
        .cnt   (lvl_cnt)
    );

    pd_odt_quiet #(.T_ANPD(T_ANPD)) u_odt (
        .clk     (clk),
        .rst_n   (rst_n),
        .odt_chg (odt_chg),
        .settled (odt_settled)
    );

    pd_exit_calc #(
        .AL_W(AL_W), .CNT_W(CNT_W), .T_XP(T_XP),
        .T_XARD(T_XARD), .T_XARDS(T_XARDS)
    ) u_calc (
        .row_open  (bank_open),
        .slow_exit (slow_exit),
        .al        (al),
        .rd_dly    (rd_dly_c),
        .hold_len  (hold_c)
    );

    // next-state decision
    always_comb begin
        state_d = state;
        unique case (state)
            S_AWAKE: begin
                if (idle_req && !burst_busy && !wake_req && odt_settled
                    && (lvl_cnt >= C_MIN)) begin
                    state_d = S_DOWN;
                end
            end
            S_DOWN: begin
                if ((wake_req || wake_pend) && (lvl_cnt >= C_MIN)) begin
                    state_d = S_EXIT;
                end
            end
            S_EXIT: begin
                if (lvl_cnt > hold_q) begin
                    state_d = S_AWAKE;
                end
            end
            default: state_d = S_AWAKE;
        endcase
        cke_d = (state_d != S_DOWN);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_AWAKE;
            cke_q       <= 1'b1;
            wake_pend   <= 1'b0;
            pd_active_q <= 1'b0;
            rd_dly_q    <= C_XP;
            hold_q      <= C_XP;
        end else begin
            state <= state_d;
            cke_q <= cke_d;
            if (state_d != S_DOWN) begin
                wake_pend <= 1'b0;
            end else if (state == S_DOWN && wake_req) begin
                wake_pend <= 1'b1;
            end
            if (state == S_AWAKE && state_d == S_DOWN) begin
                pd_active_q <= bank_open;
                rd_dly_q    <= rd_dly_c;
                hold_q      <= hold_c;
            end
        end
    end

    // outputs
    always_comb begin
        rd_ok  = 1'b0;
        nrd_ok = 1'b0;
        unique case (state)
            S_AWAKE: begin
                rd_ok  = 1'b1;
                nrd_ok = 1'b1;
            end
            S_DOWN: begin
                rd_ok  = 1'b0;
                nrd_ok = 1'b0;
            end
            S_EXIT: begin
                rd_ok  = (lvl_cnt > rd_dly_q);
                nrd_ok = (lvl_cnt > C_XP);
            end
            default: begin
                rd_ok  = 1'b0;
                nrd_ok = 1'b0;
            end
        endcase
        odt_ok = cke_q && (lvl_cnt > C_AXPD);
    end

    assign cke       = cke_q;
    assign pd_active = pd_active_q;

    // R1: type follows bank state at entry
    p_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_q) |-> (pd_active_q == $past(bank_open)));

    // R2: no entry during a burst or a wake
    p_no_busy_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_q) |-> (!$past(burst_busy) && !$past(wake_req)));

    // R3: high level lasted the minimum before a fall
    p_high_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_q) |-> ($past(lvl_cnt) >= C_MIN));

    // R3: low level lasted the minimum before a rise
    p_low_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_q) |-> ($past(lvl_cnt) >= C_MIN));

    // R4: no command allowed while CKE is low
    p_flags_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_q |-> (!rd_ok && !nrd_ok));

    // R5: a read is never allowed ahead of non-read commands
    p_rd_after_nrd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ok |-> nrd_ok);

    // R7: termination line quiet in the cycle before a fall
    p_odt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke_q) |-> !$past(odt_chg));

    // R9: termination change not allowed just after exit
    p_odt_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_q) |-> !odt_ok);
endmodule

// File: tb/test_pd_cke_manager.sv
`timescale 1ns/1ps
module test_pd_cke_manager;
    localparam int MIN_PULSE = 3;
    localparam int T_XP      = 2;
    localparam int T_XARD    = 2;
    localparam int T_XARDS   = 6;
    localparam int T_ANPD    = 3;
    localparam int T_AXPD    = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic idle_req, burst_busy, bank_open, wake_req, slow_exit, odt_chg;
    logic [2:0] al;
    logic cke, pd_active, rd_ok, nrd_ok, odt_ok;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pd_cke_manager i_pd_cke_manager (
        .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .burst_busy(burst_busy),
        .bank_open(bank_open), .wake_req(wake_req), .al(al), .slow_exit(slow_exit),
        .odt_chg(odt_chg), .cke(cke), .pd_active(pd_active), .rd_ok(rd_ok),
        .nrd_ok(nrd_ok), .odt_ok(odt_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // raise wake for one cycle, wait for CKE high and for exit to finish
    task automatic wake_and_settle();
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        for (int i = 0; i < 20 && !cke; i++) @(negedge clk);
        repeat (14) @(negedge clk);
    endtask

    // one full power-down visit with measurement of all exit delays
    task automatic pd_visit(input int bo, input int sl, input int alv);
        int lo, nrd0, rd0, odt0, exp_rd;
        bank_open = bo[0];
        slow_exit = sl[0];
        al        = alv[2:0];
        idle_req  = 1'b1;
        @(negedge clk);
        check($sformatf("R2 entry b%0d s%0d a%0d", bo, sl, alv), cke, 0);
        check($sformatf("R1 type b%0d s%0d a%0d", bo, sl, alv), pd_active, bo);
        check($sformatf("R4 flags low b%0d s%0d a%0d", bo, sl, alv), rd_ok | nrd_ok, 0);
        idle_req  = 1'b0;
        bank_open = ~bo[0];    // changes after entry must not matter
        slow_exit = ~sl[0];
        al        = 3'd0;
        wake_req  = 1'b1;
        lo = 1;
        @(negedge clk);
        wake_req = 1'b0;
        for (int i = 0; i < 20 && !cke; i++) begin
            lo++;
            @(negedge clk);
        end
        check($sformatf("R8 held wake low width b%0d s%0d a%0d", bo, sl, alv), lo, MIN_PULSE);
        nrd0 = 0; rd0 = 0; odt0 = 0;
        for (int i = 0; i < 12; i++) begin
            if (!nrd_ok) nrd0++;
            if (!rd_ok)  rd0++;
            if (!odt_ok) odt0++;
            @(negedge clk);
        end
        if (bo == 0 || sl == 0)        exp_rd = T_XARD;
        else if (T_XARDS - alv < T_XARD) exp_rd = T_XARD;
        else                           exp_rd = T_XARDS - alv;
        if (bo == 0) exp_rd = T_XP;
        check($sformatf("R5 nrd delay b%0d s%0d a%0d", bo, sl, alv), nrd0, T_XP);
        check($sformatf("R6 rd delay b%0d s%0d a%0d", bo, sl, alv), rd0, exp_rd);
        check($sformatf("R9 odt delay b%0d s%0d a%0d", bo, sl, alv), odt0, T_AXPD);
        check($sformatf("R1 type held through exit b%0d", bo), pd_active, bo);
        bank_open = 1'b0;
        slow_exit = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int hi, lo;
        rst_n = 1'b0;
        idle_req = 1'b1; burst_busy = 1'b0; bank_open = 1'b0; wake_req = 1'b0;
        slow_exit = 1'b0; odt_chg = 1'b0; al = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        check("R10 cke", cke, 1);
        check("R10 rd_ok", rd_ok, 1);
        check("R10 nrd_ok", nrd_ok, 1);
        check("R10 pd_active", pd_active, 0);
        check("R10 odt_ok", odt_ok, 0);
        // R3 high width after reset
        hi = 0;
        @(negedge clk);
        for (int i = 0; i < 20 && cke; i++) begin
            hi++;
            @(negedge clk);
        end
        check("R3 high width after reset", hi, MIN_PULSE);
        idle_req = 1'b0;
        wake_and_settle();

        // R1 R5 R6 R8 R9 sweep of type, exit mode, additive latency
        for (int bo = 0; bo < 2; bo++)
            for (int sl = 0; sl < 2; sl++)
                for (int a = 0; a < 6; a++)
                    pd_visit(bo, sl, a);

        // R2 burst in progress blocks entry
        idle_req = 1'b1; burst_busy = 1'b1;
        hi = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cke) hi++;
        end
        check("R2 burst blocks entry", hi, 8);
        burst_busy = 1'b0;
        @(negedge clk);
        check("R2 entry after burst ends", cke, 0);
        idle_req = 1'b0;
        wake_and_settle();

        // R2 wake request in awake blocks entry
        idle_req = 1'b1; wake_req = 1'b1;
        hi = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (cke) hi++;
        end
        check("R2 wake blocks entry", hi, 8);
        wake_req = 1'b0;
        @(negedge clk);
        check("R2 entry after wake drops", cke, 0);
        idle_req = 1'b0;

        // R8 wake after the low window is served at the next edge
        repeat (4) @(negedge clk);
        check("R8 stays low without wake", cke, 0);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        check("R8 late wake served at once", cke, 1);
        repeat (14) @(negedge clk);

        // R7 termination change delays entry
        odt_chg = 1'b1; idle_req = 1'b1;
        hi = 0;
        @(negedge clk);
        odt_chg = 1'b0;
        for (int i = 0; i < 20 && cke; i++) begin
            hi++;
            @(negedge clk);
        end
        check("R7 odt quiet before entry", hi, T_ANPD);
        idle_req = 1'b0;

        // R3 minimum low width with wake held from the first low cycle
        wake_req = 1'b1;
        lo = 1;
        @(negedge clk);
        for (int i = 0; i < 20 && !cke; i++) begin
            lo++;
            @(negedge clk);
        end
        wake_req = 1'b0;
        check("R3 low width with wake held", lo, MIN_PULSE);
        check("R4 flags low after exit start", rd_ok | nrd_ok, 0);
        repeat (14) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule